// File: doc/BRIEF.md
# Lowest-Priority Interrupt Redirection Arbiter

This block decides which processor should receive an interrupt that was sent with a lowest-priority hint. It keeps a bank of per-processor entries. Each entry holds an enable flag, a 4-bit task priority, an 8-bit logical ID and a physical ID, and the entries are loaded through a write port. Three 4-bit limits, written through a second port, split the priority range 0..15 into four buckets.

Each incoming request carries a hint bit, a destination-mode bit and an 8-bit destination. For a hinted request the block forms a candidate pool and maps every candidate's priority to a bucket. The candidate in the lowest bucket wins. When candidates tie on bucket, the one picked longest ago wins. The result is returned one cycle after the request is accepted. It is either a request retargeted to the winner's physical ID, or the original request passed through. Entry and limit writes stall request acceptance, so every request sees a settled bank.

Top module: `lpr_redirect_arbiter`

## Requirements
- R1: A request with hint 0 is passed through: res_hint 0, res_dmode and res_dest equal to the request's values, res_passthru 1, res_index 0.
- R2: With hint 1 and dmode 1 (flat logical), an entry is a candidate only when it is enabled and (req_dest AND its logical ID) is nonzero.
- R3: With hint 1 and dmode 0 (physical), every enabled entry is a candidate.
- R4: With hint 1 and no candidate, the result has res_hint 0, res_dmode and res_dest unchanged, res_passthru 1 and res_index 0.
- R5: With hint 1 and at least one candidate, the result has res_dest equal to the winner's physical ID, res_hint 0, res_dmode 0, res_passthru 0 and res_index equal to the winner's entry index.
- R6: Priority p maps to bucket 0 if p < lim0, to 1 if lim0 <= p < lim1, to 2 if lim1 <= p < lim2, and to 3 otherwise. After reset the limits are 4, 8 and 12.
- R7: The winner is always a candidate whose bucket is the lowest among all candidates.
- R8: Among candidates that share the lowest bucket, the one whose last pick is oldest wins. After reset a lower index counts as older. Only redirected results (R5) count as picks.
- R9: req_ready is 0 in every cycle where upd_valid or lim_valid is 1. A request accepted after a write sees the written values.
- R10: res_valid is 1 exactly in the cycle after a cycle with req_valid and req_ready both 1.
- R11: After reset every entry is disabled, so a hinted request gets the R4 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Write one entry this cycle |
| upd_index | input | $clog2(N_ENT) | Entry to write |
| upd_enable | input | 1 | Entry enable value |
| upd_prio | input | 4 | Entry task priority |
| upd_logid | input | 8 | Entry logical ID |
| upd_physid | input | 8 | Entry physical ID |
| lim_valid | input | 1 | Write the three bucket limits |
| lim0_in | input | 4 | Upper bound of bucket 0 |
| lim1_in | input | 4 | Upper bound of bucket 1 |
| lim2_in | input | 4 | Upper bound of bucket 2 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when valid |
| req_hint | input | 1 | Lowest-priority hint |
| req_dmode | input | 1 | 1 flat logical, 0 physical |
| req_dest | input | 8 | Destination ID |
| res_valid | output | 1 | Result present |
| res_hint | output | 1 | Hint of the forwarded request |
| res_dmode | output | 1 | Mode of the forwarded request |
| res_dest | output | 8 | Destination of the forwarded request |
| res_index | output | $clog2(N_ENT) | Winning entry |
| res_passthru | output | 1 | 1 when no redirection took place |

## Verification
A corrupt least-recently-picked order does not show until two or more candidates tie on bucket. The first such tie then returns the wrong res_index and res_dest one cycle after acceptance. The stimulus therefore repeats physical-mode requests over a fixed tie set, so that the rotation is visible across consecutive results. A stale bank entry or limit shows on the first request accepted after the write. A missed stall shows as res_valid in a cycle where a write was being presented.

// File: rtl/lpr_pkg.sv
`timescale 1ns/1ps
package lpr_pkg;
   localparam int PRIO_W = 4;
   localparam int LID_W  = 8;
   localparam int PID_W  = 8;
   localparam int BKT_W  = 2;

   typedef struct packed {
      logic              en;
      logic [PRIO_W-1:0] prio;
      logic [LID_W-1:0]  logid;
      logic [PID_W-1:0]  physid;
   } ent_t;

   typedef struct packed {
      logic [PRIO_W-1:0] l0;
      logic [PRIO_W-1:0] l1;
      logic [PRIO_W-1:0] l2;
   } lims_t;

   localparam lims_t LIMS_RST = '{l0: 4'd4, l1: 4'd8, l2: 4'd12};
endpackage

// File: rtl/lpr_entry_bank.sv
`timescale 1ns/1ps
module lpr_entry_bank
   import lpr_pkg::*;
#(
   parameter int N_ENT = 8,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  ent_t             wr_data,
   input  logic             lim_wr,
   input  lims_t            lim_data,
   output ent_t             ents [N_ENT],
   output lims_t            lims
);
   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ents[g] <= '0;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            ents[g] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lims <= LIMS_RST;
      end else if (lim_wr) begin
         lims <= lim_data;
      end
   end
endmodule

// File: rtl/lpr_pool_map.sv
`timescale 1ns/1ps
module lpr_pool_map
   import lpr_pkg::*;
#(
   parameter int N_ENT = 8
) (
   input  ent_t             ents [N_ENT],
   input  lims_t            lims,
   input  logic             flat,
   input  logic [LID_W-1:0] dest,
   output logic [BKT_W-1:0] bkt [N_ENT],
   output logic [N_ENT-1:0] member
);
   for (genvar g = 0; g < N_ENT; g++) begin : g_map
      always_comb begin
         if (ents[g].prio < lims.l0)      bkt[g] = 2'd0;
         else if (ents[g].prio < lims.l1) bkt[g] = 2'd1;
         else if (ents[g].prio < lims.l2) bkt[g] = 2'd2;
         else                             bkt[g] = 2'd3;
      end

      always_comb begin
         if (flat) member[g] = ents[g].en && (|(dest & ents[g].logid));
         else      member[g] = ents[g].en;
      end
   end
endmodule

// File: rtl/lpr_lru_rank.sv
`timescale 1ns/1ps
module lpr_lru_rank #(
   parameter int N_ENT = 8,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pick_en,
   input  logic [IDX_W-1:0] pick_idx,
   output logic [IDX_W-1:0] rank [N_ENT]
);
   logic [IDX_W-1:0] pick_rank;
   assign pick_rank = rank[pick_idx];

   for (genvar g = 0; g < N_ENT; g++) begin : g_rank
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rank[g] <= IDX_W'(g);
         end else if (pick_en) begin
            if (pick_idx == IDX_W'(g))     rank[g] <= IDX_W'(N_ENT - 1);
            else if (rank[g] > pick_rank)  rank[g] <= rank[g] - 1'b1;
         end
      end
   end
endmodule

// File: rtl/lpr_winner_sel.sv
`timescale 1ns/1ps
module lpr_winner_sel
   import lpr_pkg::*;
#(
   parameter int N_ENT = 8,
   localparam int IDX_W = $clog2(N_ENT),
   localparam int KEY_W = BKT_W + IDX_W
) (
   input  logic [N_ENT-1:0] member,
   input  logic [BKT_W-1:0] bkt  [N_ENT],
   input  logic [IDX_W-1:0] rank [N_ENT],
   output logic             any,
   output logic [IDX_W-1:0] win
);
   logic [KEY_W-1:0] best;

   always_comb begin
      any  = 1'b0;
      win  = '0;
      best = '1;
      for (int i = 0; i < N_ENT; i++) begin
         if (member[i] && (!any || {bkt[i], rank[i]} < best)) begin
            any  = 1'b1;
            best = {bkt[i], rank[i]};
            win  = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/lpr_redirect_arbiter.sv
`timescale 1ns/1ps
module lpr_redirect_arbiter
   import lpr_pkg::*;
#(
   parameter int N_ENT = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       upd_valid,
   input  logic [$clog2(N_ENT)-1:0]   upd_index,
   input  logic                       upd_enable,
   input  logic [3:0]                 upd_prio,
   input  logic [7:0]                 upd_logid,
   input  logic [7:0]                 upd_physid,
   input  logic                       lim_valid,
   input  logic [3:0]                 lim0_in,
   input  logic [3:0]                 lim1_in,
   input  logic [3:0]                 lim2_in,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic                       req_hint,
   input  logic                       req_dmode,
   input  logic [7:0]                 req_dest,
   output logic                       res_valid,
   output logic                       res_hint,
   output logic                       res_dmode,
   output logic [7:0]                 res_dest,
   output logic [$clog2(N_ENT)-1:0]   res_index,
   output logic                       res_passthru
);
   localparam int IDX_W = $clog2(N_ENT);

   if (N_ENT < 2) begin : g_bad_n
      $error("lpr_redirect_arbiter: N_ENT must be at least 2");
   end
   if (PRIO_W != 4 || LID_W != 8 || PID_W != 8) begin : g_bad_w
      $error("lpr_redirect_arbiter: port widths disagree with package");
   end

   ent_t             ents [N_ENT];
   lims_t            lims;
   logic [BKT_W-1:0] bkt  [N_ENT];
   logic [IDX_W-1:0] rank [N_ENT];
   logic [N_ENT-1:0] member;
   logic             any;
   logic [IDX_W-1:0] win;
   logic             fire;
   logic             redirect;

   // Writes and requests never share a cycle: the serialization point.
   assign req_ready = !upd_valid && !lim_valid;
   assign fire      = req_valid && req_ready;
   assign redirect  = fire && req_hint && any;

   lpr_entry_bank #(.N_ENT(N_ENT)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (upd_valid),
      .wr_idx   (upd_index),
      .wr_data  ('{en: upd_enable, prio: upd_prio, logid: upd_logid, physid: upd_physid}),
      .lim_wr   (lim_valid),
      .lim_data ('{l0: lim0_in, l1: lim1_in, l2: lim2_in}),
      .ents     (ents),
      .lims     (lims)
   );

   lpr_pool_map #(.N_ENT(N_ENT)) u_map (
      .ents   (ents),
      .lims   (lims),
      .flat   (req_dmode),
      .dest   (req_dest),
      .bkt    (bkt),
      .member (member)
   );

   lpr_lru_rank #(.N_ENT(N_ENT)) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .pick_en  (redirect),
      .pick_idx (win),
      .rank     (rank)
   );

   lpr_winner_sel #(.N_ENT(N_ENT)) u_sel (
      .member (member),
      .bkt    (bkt),
      .rank   (rank),
      .any    (any),
      .win    (win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_hint     <= 1'b0;
         res_dmode    <= 1'b0;
         res_dest     <= '0;
         res_index    <= '0;
         res_passthru <= 1'b0;
      end else begin
         res_valid <= fire;
         if (fire) begin
            if (redirect) begin
               res_hint     <= 1'b0;
               res_dmode    <= 1'b0;
               res_dest     <= ents[win].physid;
               res_index    <= win;
               res_passthru <= 1'b0;
            end else begin
               res_hint     <= 1'b0;
               res_dmode    <= req_dmode;
               res_dest     <= req_dest;
               res_index    <= '0;
               res_passthru <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lpr_redirect_chk.sv
`timescale 1ns/1ps
module lpr_redirect_chk #(
   parameter int N_ENT = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       upd_valid,
   input logic       lim_valid,
   input logic       req_valid,
   input logic       req_ready,
   input logic       req_hint,
   input logic       req_dmode,
   input logic [7:0] req_dest,
   input logic       res_valid,
   input logic       res_hint,
   input logic       res_dmode,
   input logic [7:0] res_dest,
   input logic       res_passthru
);
   // R10
   res_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> res_valid);

   // R10
   no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !res_valid);

   // R9
   stall_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid || lim_valid) |-> !req_ready);

   // R1
   unhinted_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_hint) |=>
         (res_passthru && !res_hint && res_dest == $past(req_dest) && res_dmode == $past(req_dmode)));

   // R5
   redirect_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_passthru) |-> (!res_hint && !res_dmode));

   // R4
   hint_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !res_hint);
endmodule

bind lpr_redirect_arbiter lpr_redirect_chk #(.N_ENT(N_ENT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .upd_valid    (upd_valid),
   .lim_valid    (lim_valid),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_hint     (req_hint),
   .req_dmode    (req_dmode),
   .req_dest     (req_dest),
   .res_valid    (res_valid),
   .res_hint     (res_hint),
   .res_dmode    (res_dmode),
   .res_dest     (res_dest),
   .res_passthru (res_passthru)
);

// File: tb/tb_lpr_redirect_arbiter.sv
`timescale 1ns/1ps
module tb_lpr_redirect_arbiter;
   localparam int N = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd_valid = 1'b0;
   logic [2:0] upd_index = '0;
   logic       upd_enable = 1'b0;
   logic [3:0] upd_prio = '0;
   logic [7:0] upd_logid = '0;
   logic [7:0] upd_physid = '0;
   logic       lim_valid = 1'b0;
   logic [3:0] lim0_in = '0, lim1_in = '0, lim2_in = '0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic       req_hint = 1'b0, req_dmode = 1'b0;
   logic [7:0] req_dest = '0;
   logic       res_valid, res_hint, res_dmode, res_passthru;
   logic [7:0] res_dest;
   logic [2:0] res_index;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   lpr_redirect_arbiter #(.N_ENT(N)) dut (.*);

   // Reference state built from the requirements
   logic       m_en [N];
   logic [3:0] m_pr [N];
   logic [7:0] m_lid [N];
   logic [7:0] m_pid [N];
   int         m_last [N];
   int         m_stamp;
   logic [3:0] m_l0, m_l1, m_l2;

   // {hint, dmode, dest}; covers R2 flat pools, R3 physical ties (R8 rotation), R6/R7 buckets
   localparam logic [9:0] VEC [14] = '{
      {1'b1, 1'b0, 8'h00}, {1'b1, 1'b0, 8'h00}, {1'b1, 1'b0, 8'h00},
      {1'b0, 1'b0, 8'h5A}, {1'b1, 1'b0, 8'h00}, {1'b1, 1'b1, 8'h05},
      {1'b1, 1'b1, 8'h20}, {1'b1, 1'b1, 8'hA0}, {1'b1, 1'b1, 8'h00},
      {1'b1, 1'b1, 8'h08}, {1'b0, 1'b1, 8'hFF}, {1'b1, 1'b1, 8'h4C},
      {1'b1, 1'b1, 8'h4C}, {1'b1, 1'b1, 8'h01}
   };

   function automatic logic [1:0] bucket_of(input logic [3:0] p);
      if (p < m_l0) return 2'd0;
      if (p < m_l1) return 2'd1;
      if (p < m_l2) return 2'd2;
      return 2'd3;
   endfunction

   task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_ent(input int i, input logic en, input logic [3:0] p,
                            input logic [7:0] lid, input logic [7:0] pid);
      @(negedge clk);
      upd_valid = 1'b1; upd_index = 3'(i); upd_enable = en;
      upd_prio = p; upd_logid = lid; upd_physid = pid;
      #1;
      n_chk++;
      if (req_ready !== 1'b0) begin
         n_bad++;
         $display("FAIL R9: req_ready actual %b expected 0 during entry write", req_ready);
      end
      @(negedge clk);
      upd_valid = 1'b0;
      m_en[i] = en; m_pr[i] = p; m_lid[i] = lid; m_pid[i] = pid;
   endtask

   task automatic write_lims(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
      @(negedge clk);
      lim_valid = 1'b1; lim0_in = a; lim1_in = b; lim2_in = c;
      @(negedge clk);
      lim_valid = 1'b0;
      m_l0 = a; m_l1 = b; m_l2 = c;
   endtask

   // Compute expected result, advance reference pick history, drive and compare
   task automatic run_req(input logic h, input logic d, input logic [7:0] dst, input string extra);
      logic [13:0] exp;
      string       tag;
      int          w;
      logic [1:0]  wb;
      w = -1; wb = 2'd3;
      if (h) begin
         for (int i = 0; i < N; i++) begin
            logic cand;
            cand = m_en[i] && (d ? (|(dst & m_lid[i])) : 1'b1);
            if (cand) begin
               if (w < 0 || bucket_of(m_pr[i]) < wb ||
                   (bucket_of(m_pr[i]) == wb && m_last[i] < m_last[w])) begin
                  w = i; wb = bucket_of(m_pr[i]);
               end
            end
         end
      end
      if (!h) begin
         tag = "R1"; exp = {1'b0, d, 1'b1, 3'd0, dst};
      end else if (w < 0) begin
         tag = "R4"; exp = {1'b0, d, 1'b1, 3'd0, dst};
      end else begin
         tag = "R5"; exp = {1'b0, 1'b0, 1'b0, 3'(w), m_pid[w]};
         m_last[w] = m_stamp; m_stamp++;
      end
      @(negedge clk);
      req_valid = 1'b1; req_hint = h; req_dmode = d; req_dest = dst;
      @(negedge clk);
      req_valid = 1'b0;
      n_chk++;
      if (res_valid !== 1'b1) begin
         n_bad++;
         $display("FAIL R10: res_valid actual %b expected 1", res_valid);
      end
      check({tag, extra}, {res_hint, res_dmode, res_passthru, res_index, res_dest}, exp);
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_en[i] = 1'b0; m_pr[i] = '0; m_lid[i] = '0; m_pid[i] = '0; m_last[i] = i - N;
      end
      m_stamp = 0; m_l0 = 4'd4; m_l1 = 4'd8; m_l2 = 4'd12;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      n_chk++;
      if (res_valid !== 1'b0 || req_ready !== 1'b1) begin
         n_bad++;
         $display("FAIL R10: reset res_valid/req_ready actual %b%b expected 01", res_valid, req_ready);
      end

      // R11: empty bank after reset
      run_req(1'b1, 1'b0, 8'h33, " R11 physical after reset");
      run_req(1'b1, 1'b1, 8'hFF, " R11 flat after reset");

      write_ent(0, 1'b1, 4'd5,  8'h01, 8'h10);
      write_ent(1, 1'b1, 4'd2,  8'h03, 8'h11);
      write_ent(2, 1'b1, 4'd9,  8'h04, 8'h12);
      write_ent(3, 1'b1, 4'd3,  8'h0C, 8'h13);
      write_ent(4, 1'b0, 4'd0,  8'hFF, 8'h14);
      write_ent(5, 1'b1, 4'd14, 8'h30, 8'h15);
      write_ent(6, 1'b1, 4'd1,  8'h40, 8'h16);
      write_ent(7, 1'b1, 4'd7,  8'h80, 8'h17);

      for (int v = 0; v < 14; v++) begin
         run_req(VEC[v][9], VEC[v][8], VEC[v][7:0], " table");
      end

      // R9: update seen by the very next accepted request
      write_ent(5, 1'b1, 4'd0, 8'h30, 8'h25);
      run_req(1'b1, 1'b0, 8'h00, " R9 R7 new priority");

      // R6: limits moved so every priority falls in bucket 3, ties decided by R8
      write_lims(4'd0, 4'd0, 4'd0);
      for (int k = 0; k < 4; k++) run_req(1'b1, 1'b0, 8'h00, " R6 R8 one bucket");
      // R6: limit equal to priority puts it in the upper bucket
      write_lims(4'd3, 4'd9, 4'd15);
      run_req(1'b1, 1'b1, 8'h0E, " R6 boundary");
      run_req(1'b1, 1'b1, 8'h0E, " R6 boundary repeat");
      // R2: disabled entry with matching logical ID never joins
      run_req(1'b1, 1'b1, 8'h00, " R2 zero dest");
      write_ent(4, 1'b1, 4'd0, 8'h00, 8'h14);
      run_req(1'b1, 1'b1, 8'hFF, " R2 zero logid");
      // R3: physical includes the newly enabled entry
      run_req(1'b1, 1'b0, 8'h99, " R3 enabled entry");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule